// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns the addresses that devices issue for DMA into physical memory addresses. It looks each address up in a translation table that lives in system memory. Software programs three things: the table's base address, whether the table is indexed by 8 KB or by 64 KB steps, and a 3-bit code that sets how much device address space the table covers. Each table entry chooses its own physical page size, 8 KB or 64 KB.

A request carries a device address and a flag that marks it as a write. The block works out where the entry sits in the table and fetches that one 64-bit entry through a simple memory read port. It then checks the entry's valid and write-permission bits. It returns either a physical address with the page size, or a fault. Only one request is handled at a time. When translation is switched off, addresses pass straight through.

A small register file holds the control and base registers. Each can be reached as a whole 64-bit word or as two 32-bit halves. A third slot, the flush slot, is a dummy.

Top module: `dma_xlate`

## Requirements
- R1: The register file decodes `cfg_addr[4:3]`: 00 is control, 01 is table base, 10 is flush and 11 is unmapped. Flush and unmapped slots always read as zero, and writes to them change no register. Both registers reset to zero.
- R2: A 32-bit access (`cfg_wide`=0) with `cfg_addr[2]`=0 reaches bits 63:32 of the register, and with `cfg_addr[2]`=1 it reaches bits 31:0. In both cases the data sits in bits 31:0 of `cfg_wdata` or `cfg_rdata`, and the rest of the read data is zero. A 64-bit access (`cfg_wide`=1) with `cfg_addr[2]`=0 reaches all 64 bits.
- R3: When control bit 0 is clear, a request does no memory fetch. It returns the request address, zero-extended, as the physical address, with fault=0, writable=1 and page64k=0.
- R4: When control bit 0 is set and bit 2 is clear (8 KB table mode), the entry address is base + (address bits 13 up to 22+code, shifted right by 10). Here code is control bits 18:16, and all values 0 to 7 are legal.
- R5: When control bits 0 and 2 are set (64 KB table mode), the entry address is base + (address bits 16 up to 25+code, shifted right by 13), for codes 0 to 5. Codes 6 and 7 give fault=1, writable=0, page64k=0 and physical address 0, with no memory fetch.
- R6: The entry is big-endian. The byte at the entry address arrives in `mem_rsp_data[7:0]` and holds entry bits 63:56. Entry bit 63 is the valid bit. A clear valid bit gives fault=1, writable=0, page64k=0 and physical address 0.
- R7: For a valid entry, `rsp_writable` equals entry bit 1. A write request to an entry whose bit 1 is clear gives fault=1. A read request to such an entry gives fault=0.
- R8: For a valid entry with bit 61 set, page64k=1 and the physical address is (entry & 0x1FFFFFF8000) | address[15:0]. When bit 61 is clear, page64k=0 and the physical address is (entry & 0x1FFFFFFE000) | address[12:0].
- R9: At most one translation is in flight, and `req_ready` is high only when the block is idle. Once `mem_rd_valid` is raised, it and `mem_rd_addr` hold until `mem_rd_ready`. Once `rsp_valid` is raised, it and the response fields hold until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data (combinational from cfg_addr and cfg_wide) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | VA_W | Device address |
| req_write | input | 1 | Request is a write |
| mem_rd_valid | output | 1 | Entry fetch request valid |
| mem_rd_ready | input | 1 | Memory accepts the fetch |
| mem_rd_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry bytes, lowest address in bits 7:0 |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address |
| rsp_page64k | output | 1 | Page is 64 KB |
| rsp_writable | output | 1 | Page allows writes |
| rsp_fault | output | 1 | Translation failed |

## Verification
The bench aims at these corner cases:
- Unsupported 64 KB table codes 6 and 7. A design that decoded them like legal codes would issue a stray fetch and return a mapping where a fault belongs.
- The largest 8 KB code, with address bits set right up to the top of the index field. A mask that is one bit short or one bit long would fetch the wrong entry address.
- Byte order of the fetched entry. Getting it wrong moves the valid, size and write bits, so good entries show up as faults.
- Writes to read-only pages, and 64 KB entries whose page offset overlaps base bit 15. Each of these would come back with the wrong fault flag or the wrong physical address.
- Half-register access and flush-slot writes. A wrong half-select, or a flush write that leaked into a register, would corrupt the readback of control or base.

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int VA_W = 32,
  parameter int PA_W = 41
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_wide,
  input  logic [4:0]      cfg_addr,
  input  logic [63:0]     cfg_wdata,
  output logic [63:0]     cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_addr,
  input  logic            req_write,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [63:0]     mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_page64k,
  output logic            rsp_writable,
  output logic            rsp_fault
);
  localparam logic [PA_W-1:0] BASE64_MASK = {{(PA_W-15){1'b1}}, 15'b0};
  localparam logic [PA_W-1:0] BASE8_MASK  = {{(PA_W-13){1'b1}}, 13'b0};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} state_t;
  state_t state;

  logic [63:0] ctrl_q, base_q;
  logic [VA_W-1:0] addr_q;
  logic write_q;
  logic [63:0] fetch_q;
  logic [PA_W-1:0] pa_q;
  logic p64_q, wok_q, flt_q;

  function automatic logic [63:0] merge(input logic [63:0] old, input logic wide,
                                        input logic lo, input logic [63:0] wd);
    if (wide && !lo) return wd;
    if (lo)          return {old[63:32], wd[31:0]};
    return {wd[31:0], old[31:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr[4:3] == 2'b00) ctrl_q <= merge(ctrl_q, cfg_wide, cfg_addr[2], cfg_wdata);
      if (cfg_addr[4:3] == 2'b01) base_q <= merge(base_q, cfg_wide, cfg_addr[2], cfg_wdata);
    end
  end

  logic [63:0] sel_reg;
  assign sel_reg   = (cfg_addr[4:3] == 2'b00) ? ctrl_q :
                     (cfg_addr[4:3] == 2'b01) ? base_q : 64'd0;
  assign cfg_rdata = (cfg_wide && !cfg_addr[2]) ? sel_reg :
                     cfg_addr[2] ? {32'd0, sel_reg[31:0]} : {32'd0, sel_reg[63:32]};

  logic       xl_en, tbl64;
  logic [2:0] code;
  logic       bad_code;
  logic [5:0] idx_bits;
  logic [63:0] idx_mask, shifted, fetch_addr;
  assign xl_en      = ctrl_q[0];
  assign tbl64      = ctrl_q[2];
  assign code       = ctrl_q[18:16];
  assign bad_code   = tbl64 && (code[2:1] == 2'b11);
  assign idx_bits   = 6'd10 + {3'd0, code};
  assign idx_mask   = (64'd1 << idx_bits) - 64'd1;
  assign shifted    = tbl64 ? (64'(req_addr) >> 16) : (64'(req_addr) >> 13);
  assign fetch_addr = base_q + ((shifted & idx_mask) << 3);

  logic [63:0] entry;
  always_comb
    for (int i = 0; i < 8; i++) entry[8*i +: 8] = mem_rsp_data[8*(7-i) +: 8];

  logic [PA_W-1:0] ent_pa, pa_xl;
  assign ent_pa = entry[PA_W-1:0];
  assign pa_xl  = entry[61] ? ((ent_pa & BASE64_MASK) | PA_W'(addr_q[15:0]))
                            : ((ent_pa & BASE8_MASK)  | PA_W'(addr_q[12:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      fetch_q <= '0;
      pa_q    <= '0;
      p64_q   <= 1'b0;
      wok_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          write_q <= req_write;
          fetch_q <= fetch_addr;
          p64_q   <= 1'b0;
          if (!xl_en) begin
            pa_q  <= PA_W'(req_addr);
            wok_q <= 1'b1;
            flt_q <= 1'b0;
            state <= S_RESP;
          end else if (bad_code) begin
            pa_q  <= '0;
            wok_q <= 1'b0;
            flt_q <= 1'b1;
            state <= S_RESP;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: if (mem_rd_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!entry[63]) begin
            pa_q  <= '0;
            p64_q <= 1'b0;
            wok_q <= 1'b0;
            flt_q <= 1'b1;
          end else begin
            pa_q  <= pa_xl;
            p64_q <= entry[61];
            wok_q <= entry[1];
            flt_q <= write_q && !entry[1];
          end
          state <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FETCH);
  assign mem_rd_addr  = fetch_q;
  assign rsp_valid    = (state == S_RESP);
  assign rsp_paddr    = pa_q;
  assign rsp_page64k  = p64_q;
  assign rsp_writable = wok_q;
  assign rsp_fault    = flt_q;

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_rd_valid || rsp_valid));
  assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
  assert_flush_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr[4] |-> cfg_rdata == 64'd0);
  assert_ro_write_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && write_q && !rsp_writable |-> rsp_fault);
  assert_bypass_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !ctrl_q[0] |=> rsp_valid);
endmodule

// File: tb/dma_xlate_bench.sv
`timescale 1ns/1ps
module dma_xlate_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_wide = 0;
  logic [4:0] cfg_addr = 0;
  logic [63:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = 0;
  logic mem_rd_valid, mem_rd_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_rd_addr, mem_rsp_data = 0;
  logic rsp_valid, rsp_ready = 0, rsp_page64k, rsp_writable, rsp_fault;
  logic [40:0] rsp_paddr;

  int checks = 0, errors = 0, fetches = 0, pend = 0;
  logic [63:0] cur_entry = 0, seen_addr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_xlate u_dma_xlate (.*);

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] o;
    for (int i = 0; i < 8; i++) o[8*i +: 8] = v[8*(7-i) +: 8];
    return o;
  endfunction

  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 0;
    if (pend > 0) begin
      mem_rd_ready = 0;
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data = bswap(cur_entry);
      end
    end else if (mem_rd_valid) begin
      mem_rd_ready = $urandom % 2;
      if (mem_rd_ready) begin
        seen_addr = mem_rd_addr;
        fetches++;
        pend = 1 + $urandom % 3;
      end
    end else mem_rd_ready = 0;
  end

  task automatic cfg_wr(input bit wide, input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_wide = wide; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(input bit wide, input logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    cfg_wide = wide; cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic model(input logic [63:0] c, b, e, input logic [31:0] a, input bit w,
                       output bit xf, xw, x64, output logic [40:0] xpa,
                       output bit xfetch, output logic [63:0] xma);
    int lo, hi;
    logic [63:0] off;
    xf = 0; xw = 0; x64 = 0; xpa = 0; xfetch = 0; xma = 0;
    if (!c[0]) begin
      xpa = 41'(a); xw = 1;
    end else if (c[2] && c[18:16] >= 6) begin
      xf = 1;
    end else begin
      lo = c[2] ? 16 : 13;
      hi = (c[2] ? 25 : 22) + int'(c[18:16]);
      off = 0;
      for (int i = lo; i <= hi; i++) off[i] = a[i];
      off = c[2] ? off >> 13 : off >> 10;
      xma = b + off; xfetch = 1;
      if (!e[63]) xf = 1;
      else begin
        xw = e[1]; xf = w && !e[1]; x64 = e[61];
        xpa = e[61] ? ((e[40:0] & 41'h1FFFFFF8000) | 41'(a[15:0]))
                    : ((e[40:0] & 41'h1FFFFFFE000) | 41'(a[12:0]));
      end
    end
  endtask

  task automatic xlate(input logic [63:0] c, b, e, input logic [31:0] a, input bit w, input string r);
    bit xf, xw, x64, xfetch, seen;
    logic [40:0] xpa;
    logic [63:0] xma;
    int f0;
    model(c, b, e, a, w, xf, xw, x64, xpa, xfetch, xma);
    cur_entry = e;
    f0 = fetches;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    seen = 0;
    while (1) begin
      if (rsp_valid) begin
        if (!seen) begin
          seen = 1;
          chk(rsp_paddr == xpa, r, 64'(rsp_paddr), 64'(xpa));
          chk(rsp_fault == xf, r, 64'(rsp_fault), 64'(xf));
          chk(rsp_writable == xw, r, 64'(rsp_writable), 64'(xw));
          chk(rsp_page64k == x64, r, 64'(rsp_page64k), 64'(x64));
          chk((fetches - f0) == int'(xfetch), r, 64'(fetches - f0), 64'(xfetch));
          if (xfetch) chk(seen_addr == xma, r, seen_addr, xma);
        end
        rsp_ready = $urandom % 2;
        if (rsp_ready) begin
          @(negedge clk);
          rsp_ready = 0;
          break;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input logic [63:0] c, b);
    cfg_wr(1, 5'h00, c);
    cfg_wr(0, 5'h08, {32'd0, b[63:32]});
    cfg_wr(0, 5'h0C, {32'd0, b[31:0]});
  endtask

  initial begin
    logic [63:0] v;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg_rd(1, 5'h00, v);
    chk(v == 0 && req_ready && !rsp_valid && !mem_rd_valid, "R1 reset", v, 0);

    cfg_wr(1, 5'h08, 64'h1122334455667788);
    cfg_rd(0, 5'h08, v); chk(v == 64'h11223344, "R2 upper half read", v, 64'h11223344);
    cfg_rd(0, 5'h0C, v); chk(v == 64'h55667788, "R2 lower half read", v, 64'h55667788);
    cfg_wr(0, 5'h08, 64'hFFFF0000AABBCCDD);
    cfg_rd(1, 5'h08, v); chk(v == 64'hAABBCCDD55667788, "R2 upper half write", v, 64'hAABBCCDD55667788);
    cfg_wr(0, 5'h04, 64'h00000000000500FF);
    cfg_rd(1, 5'h00, v); chk(v == 64'h500FF, "R2 lower half ctrl", v, 64'h500FF);
    cfg_wr(1, 5'h10, 64'hDEADBEEFDEADBEEF);
    cfg_wr(0, 5'h14, 64'hDEADBEEF);
    cfg_rd(1, 5'h10, v); chk(v == 0, "R1 flush reads zero", v, 0);
    cfg_rd(1, 5'h00, v); chk(v == 64'h500FF, "R1 flush write ignored ctrl", v, 64'h500FF);
    cfg_rd(1, 5'h08, v); chk(v == 64'hAABBCCDD55667788, "R1 flush write ignored base", v, 64'hAABBCCDD55667788);
    cfg_rd(1, 5'h18, v); chk(v == 0, "R1 unmapped reads zero", v, 0);

    set_cfg(64'h0, 64'h1000);
    xlate(64'h0, 64'h1000, 64'h0, 32'hDEADBEEF, 1, "R3 bypass");
    set_cfg(64'h60005, 64'h4000_0000);
    xlate(64'h60005, 64'h4000_0000, 64'h8000_0000_0000_2002, 32'h1234_5678, 0, "R5 code6 fault");
    set_cfg(64'h70005, 64'h4000_0000);
    xlate(64'h70005, 64'h4000_0000, 64'h8000_0000_0000_2002, 32'h1234_5678, 0, "R5 code7 fault");
    set_cfg(64'h70001, 64'h8000);
    xlate(64'h70001, 64'h8000, 64'h8000_0123_4567_A002, 32'h3FFF_FFFF, 1, "R4 code7 top index");
    set_cfg(64'h00001, 64'h8000);
    xlate(64'h00001, 64'h8000, 64'h0000_0123_4567_A002, 32'h0077_E123, 0, "R6 invalid entry");
    xlate(64'h00001, 64'h8000, 64'h8000_0000_ABCD_E000, 32'h0077_E123, 1, "R7 write to read-only");
    xlate(64'h00001, 64'h8000, 64'h8000_0000_ABCD_E000, 32'h0077_E123, 0, "R7 read of read-only");
    set_cfg(64'h50005, 64'h2_0000);
    xlate(64'h50005, 64'h2_0000, 64'hA000_01FF_FFFF_8002, 32'h7FFF_FFFF, 1, "R8 64K page");

    for (int n = 0; n < 300; n++) begin
      logic [63:0] c, b, e;
      c = {$urandom, $urandom};
      c[0] = ($urandom % 8) != 0;
      b = {$urandom, $urandom};
      e = {$urandom, $urandom};
      set_cfg(c, b);
      xlate(c, b, e, $urandom, $urandom % 2, "R4 R5 R6 R7 R8 R9 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule